// File: doc/BRIEF.md
# Indexed Address Pointer Unit

This block holds the address pointers that walk the regions of a 2048-word shared memory. It has ten pointer registers: a master index at position 0 and five region index registers at positions 1 to 5. These cover vector, header/trailer, macro, sequencer and bridge-support data. The four address registers sit at positions 6 to 9: transmit data, receive data, expected data and mask. One host write to the master index loads all four address registers at once. Each address register gets its own fixed base plus the written offset, taken modulo 2048.

Every pointer except the master index advances by one on a per-pointer increment request, which the memory-side logic raises for each access to that region. The block also decodes the host address. It produces one-hot write enables for eight control/status registers, a select that steers the read capture path to memory data, and read-back of every pointer. The memory and the host handshake sit outside the block.

Top module: `addr_ptr_unit`

## Requirements
- R1: After reset, all ten pointers read 0.
- R2: A write to host address 0 (master index) stores the low 11 bits of the data in the master index. In the same edge it loads transmit, receive, expected and mask pointers with (BASE_TX, BASE_RX, BASE_EXP, BASE_MASK respectively + offset) mod 2048. Region index registers 1 to 5 do not change.
- R3: incReq bit k (k = 0..8) advances pointer k+1 by one on the next edge. Pointers with no request and no write hold their value. The master index has no increment.
- R4: A pointer at 2047 that is incremented becomes 0.
- R5: A master-index write in the same cycle as increment requests loads the address registers from the offset and ignores their requests. The region index registers still increment.
- R6: A host write to address i (i = 1..9) loads pointer i with the low 11 bits of the data, and this takes priority over a same-cycle increment of that pointer.
- R7: With hostWr high and hostAddr = 16+k (k = 0..7), csrWrEn has only bit k set in the same cycle. In all other cases csrWrEn is 0.
- R8: rdSelMem is high exactly when hostRd is high and hostAddr bit 5 is 1 (addresses 32 to 63 form the memory window).
- R9: With hostRd high, rdData shows pointer i zero-extended for hostAddr = i (i = 0..9). It shows 0 for every other address.
- R10: Host writes to addresses 10 to 15, 16 to 31 and 32 to 63 change no pointer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| hostAddr | input | 6 | Host register/memory address |
| hostWr | input | 1 | Host write strobe, one cycle per write |
| hostRd | input | 1 | Host read strobe |
| hostWrData | input | 16 | Host write data; low 11 bits used by pointers |
| incReq | input | 9 | Per-pointer increment requests, bit k for pointer k+1 |
| ptrFlat | output | 99 | Pointers 1..9, pointer k+1 in bits [11k+10:11k] |
| csrWrEn | output | 8 | One-hot control/status register write enables |
| rdSelMem | output | 1 | Read capture takes memory data |
| rdData | output | 16 | Pointer read-back data |

## Verification
The bench keeps the default build: 11-bit pointers, 16-bit host data, bases 0, 512, 1024 and 1536. With this build every master offset from 0 to 2047 can be swept, so each base-plus-offset sum is checked, including the mask sums that cross 2048. The small 6-bit host address space lets the bench sweep every address for the enable decode, the memory select and the read-back. The 11-bit pointers let it drive each of the nine counting pointers to the wrap point.

// File: rtl/ptr_unit_pkg.sv
package ptr_unit_pkg;
  localparam int NUM_IDX    = 6;
  localparam int NUM_ADDR   = 4;
  localparam int NUM_PTR    = NUM_IDX + NUM_ADDR;
  localparam int NUM_AUTO   = NUM_PTR - 1;
  localparam int FIRST_ADDR = NUM_IDX;
  localparam int NUM_CSR    = 8;
  localparam int SEL_W      = 4;

  typedef struct packed {
    logic                 masterWr;
    logic [NUM_PTR-1:0]   ptrWr;
    logic [NUM_CSR-1:0]   csrWr;
    logic                 rdMem;
    logic                 rdReg;
    logic [SEL_W-1:0]     rdIdx;
  } ptr_ctrl_t;
endpackage

// File: rtl/ptr_ctrl.sv
module ptr_ctrl
  import ptr_unit_pkg::*;
#(
  parameter int HAW = 6
) (
  input  logic [HAW-1:0] hostAddr,
  input  logic           hostWr,
  input  logic           hostRd,
  output ptr_ctrl_t      ctrl
);
  logic [SEL_W-1:0] lowIdx;
  logic [1:0]       region;
  logic             isPtr;
  logic             isCsr;
  logic             isMem;

  assign lowIdx = hostAddr[SEL_W-1:0];
  assign region = hostAddr[HAW-1:HAW-2];
  assign isPtr  = (region == 2'b00) && (lowIdx < SEL_W'(NUM_PTR));
  assign isCsr  = (region == 2'b01) && (lowIdx < SEL_W'(NUM_CSR));
  assign isMem  = hostAddr[HAW-1];

  always_comb begin
    ctrl = '0;
    for (int k = 0; k < NUM_PTR; k++) begin
      if (hostWr && isPtr && (lowIdx == SEL_W'(k))) ctrl.ptrWr[k] = 1'b1;
    end
    ctrl.masterWr = hostWr && isPtr && (lowIdx == '0);
    for (int k = 0; k < NUM_CSR; k++) begin
      if (hostWr && isCsr && (lowIdx == SEL_W'(k))) ctrl.csrWr[k] = 1'b1;
    end
    ctrl.rdMem = hostRd && isMem;
    ctrl.rdReg = hostRd && isPtr;
    ctrl.rdIdx = lowIdx;
  end
endmodule

// File: rtl/ptr_dp.sv
module ptr_dp
  import ptr_unit_pkg::*;
#(
  parameter int AW        = 11,
  parameter int HDW       = 16,
  parameter int BASE_TX   = 0,
  parameter int BASE_RX   = 512,
  parameter int BASE_EXP  = 1024,
  parameter int BASE_MASK = 1536
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  ptr_ctrl_t              ctrl,
  input  logic [HDW-1:0]         wrData,
  input  logic [NUM_AUTO-1:0]    incReq,
  output logic [NUM_AUTO*AW-1:0] ptrFlat,
  output logic [HDW-1:0]         rdData
);
  logic [NUM_PTR-1:0][AW-1:0] ptrQ;
  logic [AW-1:0]              wrOff;

  assign wrOff = wrData[AW-1:0];

  function automatic logic [AW-1:0] baseOf(input int j);
    case (j)
      0:       return AW'(BASE_TX);
      1:       return AW'(BASE_RX);
      2:       return AW'(BASE_EXP);
      default: return AW'(BASE_MASK);
    endcase
  endfunction

  for (genvar i = 0; i < NUM_PTR; i++) begin : g_ptr
    logic [AW-1:0] q;
    if (i == 0) begin : g_master
      always_ff @(posedge clk) begin
        if (!rstN)              q <= '0;
        else if (ctrl.ptrWr[i]) q <= wrOff;
      end
    end else if (i < FIRST_ADDR) begin : g_index
      always_ff @(posedge clk) begin
        if (!rstN)              q <= '0;
        else if (ctrl.ptrWr[i]) q <= wrOff;
        else if (incReq[i-1])   q <= q + AW'(1);
      end
    end else begin : g_address
      always_ff @(posedge clk) begin
        if (!rstN)              q <= '0;
        else if (ctrl.masterWr) q <= wrOff + baseOf(i - FIRST_ADDR);
        else if (ctrl.ptrWr[i]) q <= wrOff;
        else if (incReq[i-1])   q <= q + AW'(1);
      end
    end
    assign ptrQ[i] = q;
    if (i > 0) begin : g_out
      assign ptrFlat[(i-1)*AW +: AW] = q;
    end
  end

  always_comb begin
    rdData = '0;
    for (int k = 0; k < NUM_PTR; k++) begin
      if (ctrl.rdReg && (ctrl.rdIdx == SEL_W'(k))) rdData = HDW'(ptrQ[k]);
    end
  end
endmodule

// File: rtl/addr_ptr_unit.sv
module addr_ptr_unit
  import ptr_unit_pkg::*;
#(
  parameter int AW        = 11,
  parameter int HDW       = 16,
  parameter int HAW       = 6,
  parameter int BASE_TX   = 0,
  parameter int BASE_RX   = 512,
  parameter int BASE_EXP  = 1024,
  parameter int BASE_MASK = 1536
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic [HAW-1:0]         hostAddr,
  input  logic                   hostWr,
  input  logic                   hostRd,
  input  logic [HDW-1:0]         hostWrData,
  input  logic [NUM_AUTO-1:0]    incReq,
  output logic [NUM_AUTO*AW-1:0] ptrFlat,
  output logic [NUM_CSR-1:0]     csrWrEn,
  output logic                   rdSelMem,
  output logic [HDW-1:0]         rdData
);
  ptr_ctrl_t ctrl;

  ptr_ctrl #(.HAW(HAW)) u_ctrl (
    .hostAddr(hostAddr),
    .hostWr  (hostWr),
    .hostRd  (hostRd),
    .ctrl    (ctrl)
  );

  ptr_dp #(
    .AW(AW), .HDW(HDW), .BASE_TX(BASE_TX), .BASE_RX(BASE_RX),
    .BASE_EXP(BASE_EXP), .BASE_MASK(BASE_MASK)
  ) u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .ctrl   (ctrl),
    .wrData (hostWrData),
    .incReq (incReq),
    .ptrFlat(ptrFlat),
    .rdData (rdData)
  );

  assign csrWrEn  = ctrl.csrWr;
  assign rdSelMem = ctrl.rdMem;
endmodule

// File: rtl/ptr_unit_chk.sv
module ptr_unit_chk
  import ptr_unit_pkg::*;
#(
  parameter int AW      = 11,
  parameter int HDW     = 16,
  parameter int HAW     = 6,
  parameter int BASE_TX = 0
) (
  input logic                   clk,
  input logic                   rstN,
  input logic [HAW-1:0]         hostAddr,
  input logic                   hostWr,
  input logic                   hostRd,
  input logic [HDW-1:0]         hostWrData,
  input logic [NUM_AUTO-1:0]    incReq,
  input logic [NUM_AUTO*AW-1:0] ptrFlat,
  input logic [NUM_CSR-1:0]     csrWrEn,
  input logic                   rdSelMem,
  input logic [HDW-1:0]         rdData
);
  logic [AW-1:0] txPtr;
  logic [AW-1:0] firstIdx;
  assign txPtr    = ptrFlat[(FIRST_ADDR-1)*AW +: AW];
  assign firstIdx = ptrFlat[AW-1:0];

  // R7
  csr_onehot_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(csrWrEn));
  // R7
  csr_needs_wr_chk: assert property (@(posedge clk) disable iff (!rstN)
    (csrWrEn != '0) |-> hostWr);
  // R8
  mem_sel_rd_chk: assert property (@(posedge clk) disable iff (!rstN)
    rdSelMem |-> hostRd);
  // R9
  mem_read_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    rdSelMem |-> (rdData == '0));
  // R2
  master_load_tx_chk: assert property (@(posedge clk) disable iff (!rstN)
    (hostWr && hostAddr == '0) |=> (txPtr == AW'(BASE_TX) + $past(hostWrData[AW-1:0])));
  // R3
  idx_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!hostWr && !incReq[0]) |=> $stable(firstIdx));
  // R4
  idx_wrap_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!hostWr && incReq[0] && firstIdx == '1) |=> (firstIdx == '0));
endmodule

bind addr_ptr_unit ptr_unit_chk #(
  .AW(AW), .HDW(HDW), .HAW(HAW), .BASE_TX(BASE_TX)
) u_chk (
  .clk(clk), .rstN(rstN), .hostAddr(hostAddr), .hostWr(hostWr), .hostRd(hostRd),
  .hostWrData(hostWrData), .incReq(incReq), .ptrFlat(ptrFlat), .csrWrEn(csrWrEn),
  .rdSelMem(rdSelMem), .rdData(rdData)
);

// File: tb/addr_ptr_unit_bench.sv
module addr_ptr_unit_bench;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 11;
  localparam int HDW = 16;
  localparam int HAW = 6;
  localparam int NPTR = 10;
  localparam int NAUTO = 9;
  localparam int DEPTH = 2048;
  localparam int BASES[4] = '{0, 512, 1024, 1536};

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [HAW-1:0] hostAddr = '0;
  logic hostWr = 1'b0;
  logic hostRd = 1'b0;
  logic [HDW-1:0] hostWrData = '0;
  logic [NAUTO-1:0] incReq = '0;
  logic [NAUTO*AW-1:0] ptrFlat;
  logic [7:0] csrWrEn;
  logic rdSelMem;
  logic [HDW-1:0] rdData;

  int checks = 0;
  int fails = 0;
  int model[NPTR];

  always #(CLK_PERIOD/2) clk = ~clk;

  addr_ptr_unit #(
    .AW(AW), .HDW(HDW), .HAW(HAW), .BASE_TX(BASES[0]), .BASE_RX(BASES[1]),
    .BASE_EXP(BASES[2]), .BASE_MASK(BASES[3])
  ) u_addr_ptr_unit (
    .clk(clk), .rstN(rstN), .hostAddr(hostAddr), .hostWr(hostWr), .hostRd(hostRd),
    .hostWrData(hostWrData), .incReq(incReq), .ptrFlat(ptrFlat), .csrWrEn(csrWrEn),
    .rdSelMem(rdSelMem), .rdData(rdData)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic readReg(input int a, output int v);
    hostAddr = HAW'(a);
    hostRd = 1'b1;
    #1;
    v = int'(rdData);
    hostRd = 1'b0;
    #1;
  endtask

  function automatic int autoPtr(input int i);
    return int'(ptrFlat[(i-1)*AW +: AW]);
  endfunction

  // drive at negedge, registers update at the following posedge, sample at next negedge
  task automatic hostWrite(input int a, input int d, input logic [NAUTO-1:0] inc);
    hostAddr = HAW'(a);
    hostWrData = HDW'(d);
    hostWr = 1'b1;
    incReq = inc;
    @(negedge clk);
    hostWr = 1'b0;
    incReq = '0;
  endtask

  task automatic checkAll(input string req);
    int v;
    for (int i = 1; i < NPTR; i++) check(req, autoPtr(i), model[i]);
    readReg(0, v);
    check(req, v, model[0]);
  endtask

  initial begin
    int v;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    for (int i = 0; i < NPTR; i++) model[i] = 0;
    checkAll("R1");

    // R7 / R10: enable decode sweep, no pointer disturbed by non-pointer writes
    for (int a = 0; a < 64; a++) begin
      hostAddr = HAW'(a);
      hostWr = 1'b0;
      #1;
      check("R7", int'(csrWrEn), 0);
    end
    for (int a = 10; a < 64; a++) begin
      hostAddr = HAW'(a);
      hostWrData = 16'h07FF;
      hostWr = 1'b1;
      #1;
      check("R7", int'(csrWrEn), (a >= 16 && a < 24) ? (1 << (a - 16)) : 0);
      @(negedge clk);
      hostWr = 1'b0;
    end
    checkAll("R10");

    // R8: memory select sweep
    for (int a = 0; a < 64; a++) begin
      hostAddr = HAW'(a);
      hostRd = 1'b1;
      #1;
      check("R8", int'(rdSelMem), (a >= 32) ? 1 : 0);
      hostRd = 1'b0;
      #1;
      check("R8", int'(rdSelMem), 0);
    end

    // R6: direct loads of region index registers
    for (int i = 1; i < 6; i++) begin
      hostWrite(i, 11 * i, '0);
      model[i] = 11 * i;
    end
    checkAll("R6");

    // R2: every master offset
    for (int off = 0; off < DEPTH; off++) begin
      hostWrite(0, off, '0);
      model[0] = off;
      for (int j = 0; j < 4; j++) model[6 + j] = (BASES[j] + off) % DEPTH;
      for (int j = 0; j < 4; j++) check("R2", autoPtr(6 + j), model[6 + j]);
      for (int i = 1; i < 6; i++) check("R2", autoPtr(i), model[i]);
      if (off % 256 == 0) begin
        readReg(0, v);
        check("R2", v, off);
      end
    end

    // R3 / R4: per-pointer increment and wrap
    for (int p = 1; p < NPTR; p++) begin
      hostWrite(p, 2046, '0);
      model[p] = 2046;
      hostWrite(63, 0, NAUTO'(1) << (p - 1));
      model[p] = 2047;
      checkAll("R3");
      hostWrite(63, 0, NAUTO'(1) << (p - 1));
      model[p] = 0;
      checkAll("R4");
      @(negedge clk);
      checkAll("R3");
    end

    // R5: master write against all increments
    hostWrite(0, 100, '1);
    model[0] = 100;
    for (int i = 1; i < 6; i++) model[i] = (model[i] + 1) % DEPTH;
    for (int j = 0; j < 4; j++) model[6 + j] = (BASES[j] + 100) % DEPTH;
    checkAll("R5");

    // R6: direct write beats same-cycle increment
    hostWrite(3, 777, '1);
    for (int i = 1; i < NPTR; i++) model[i] = (i == 3) ? 777 : (model[i] + 1) % DEPTH;
    checkAll("R6");
    hostWrite(8, 1234, '1);
    for (int i = 1; i < NPTR; i++) model[i] = (i == 8) ? 1234 : (model[i] + 1) % DEPTH;
    checkAll("R6");

    // R9: read-back sweep
    for (int i = 0; i < NPTR; i++) begin
      hostWrite(i, i * 100 + 7, '0);
      model[i] = i * 100 + 7;
    end
    for (int a = 0; a < 64; a++) begin
      readReg(a, v);
      check("R9", v, (a < NPTR) ? model[a] : 0);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule